// File: doc/BRIEF.md
# Programmable Up-Counting PWM Timer

This block is a free-running up-counter with a programmable start value, a compare register and one pulse-width-modulated output pin. Software sets it up through a small synchronous register bus. The counter advances once for each cycle in which the tick enable input is high and counting has been started. When the count passes the all-ones value it either reloads from the load register or, in one-shot mode, halts. When the compare feature is enabled, a match event fires on a tick where the count equals the compare register. The output pin reacts to a selectable set of these events. It can either emit a single-cycle pulse or invert its level.

A duty cycle is set by choosing the load value, which fixes the period as the all-ones value minus the load plus one ticks, and the compare value, which sets the position of the second edge within that period. Software can preset the counter directly. A write to the reload-trigger register copies the load value into the counter at once. Either of two soft-reset bits returns the whole block to its reset state. A status register reports when that reset has completed.

Top module: `pwm_timer`

## Requirements
- R1: Registers sit at these byte offsets: counter 0x028, load 0x02C, compare 0x038, mode 0x024. The mode register keeps only bits 0, 1, 6, 10, 11 and 12 and reads zero in every other bit. The reload-trigger (0x030) and interface-control (0x040) registers read as zero.
- R2: While mode bit 0 (run) is 1, the counter increments by one in each cycle where tickEn is high. It holds its value when tickEn is low or run is 0.
- R3: With mode bit 1 (auto-reload) set, a tick at count 0xFFFFFFFF reloads the load value. The period is therefore 0xFFFFFFFF - load + 1 ticks.
- R4: With auto-reload clear, a tick at count 0xFFFFFFFF keeps the count at 0xFFFFFFFF and clears run, which reads back as mode bit 0 = 0.
- R5: A compare event fires only on a running tick where mode bit 6 (compare enable) is 1 and the count equals the compare register.
- R6: Mode bits 11:10 select which events drive the pin: 0 selects none, 1 selects overflow only, and 2 or 3 select both overflow and compare.
- R7: When mode bit 12 is 0, the pin is high for exactly the one clock cycle after each selected event. When mode bit 12 is 1, the pin inverts on each selected event.
- R8: Writing the counter register presets the count. Any write to the reload-trigger register copies the load value into the count. A bus write takes priority over a tick in the same cycle.
- R9: Writing a 1 to bit 1 of the configuration register (0x010), or to bit 1 of the interface-control register (0x040), clears every register and drives the pin low. Status (0x014) bit 0 reads 0 in the cycle after such a write and after hardware reset, and reads 1 from the following cycle on.
- R10: Configuration bit 5 is stored and reads back at bit 5. A configuration write with bit 1 at 0 changes no other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaled count tick |
| busAddr | input | ADDR_W (8) | Register byte offset |
| busWe | input | 1 | Write strobe |
| busWdata | input | DW (32) | Write data |
| busRdata | output | DW (32) | Read data, combinational from busAddr |
| pwmOut | output | 1 | PWM output pin |

## Verification
The assertions assume that busAddr and busWdata are stable and defined whenever busWe is high, and that tickEn is a clean single-bit level. They also assume that the mode fields do not change in the same cycle as the event whose effect they check. The stimulus changes inputs only at falling clock edges. It rewrites the mode register only while tickEn is low. It keeps overflow and compare events at least one tick apart in pulse mode, so that each pulse can be counted as its own rising edge.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam logic [7:0] OFF_CFG   = 8'h10;
  localparam logic [7:0] OFF_STAT  = 8'h14;
  localparam logic [7:0] OFF_MODE  = 8'h24;
  localparam logic [7:0] OFF_CNT   = 8'h28;
  localparam logic [7:0] OFF_LOAD  = 8'h2C;
  localparam logic [7:0] OFF_TRIG  = 8'h30;
  localparam logic [7:0] OFF_CMP   = 8'h38;
  localparam logic [7:0] OFF_SICR  = 8'h40;

  localparam int MODE_RUN = 0;
  localparam int MODE_AR  = 1;
  localparam int MODE_CE  = 6;
  localparam int MODE_TRG = 10;
  localparam int MODE_PT  = 12;
  localparam int CFG_SRST = 1;
  localparam int CFG_EMU  = 5;
  localparam int SICR_SRST = 1;

  typedef struct packed {
    logic       clear;
    logic       cntWr;
    logic       trgLoad;
    logic       run;
    logic       autoReload;
    logic       cmpEn;
    logic [1:0] trigSel;
    logic       toggle;
  } core_cmd_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DW-1:0]     busWdata,
  input  logic [DW-1:0]     countVal,
  input  logic              oneShotDone,
  output logic [DW-1:0]     busRdata,
  output core_cmd_t         cmd,
  output logic [DW-1:0]     loadQ,
  output logic [DW-1:0]     cmpQ
);
  logic       selCfg, selStat, selMode, selCnt, selLoad, selTrig, selCmp, selSicr;
  logic       softRst;
  logic       runQ, arQ, ceQ, ptQ, emuQ, doneQ;
  logic [1:0] trgQ;

  assign selCfg  = busAddr == ADDR_W'(OFF_CFG);
  assign selStat = busAddr == ADDR_W'(OFF_STAT);
  assign selMode = busAddr == ADDR_W'(OFF_MODE);
  assign selCnt  = busAddr == ADDR_W'(OFF_CNT);
  assign selLoad = busAddr == ADDR_W'(OFF_LOAD);
  assign selTrig = busAddr == ADDR_W'(OFF_TRIG);
  assign selCmp  = busAddr == ADDR_W'(OFF_CMP);
  assign selSicr = busAddr == ADDR_W'(OFF_SICR);

  assign softRst = busWe && ((selCfg && busWdata[CFG_SRST]) ||
                             (selSicr && busWdata[SICR_SRST]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0; arQ <= 1'b0; ceQ <= 1'b0; ptQ <= 1'b0;
      trgQ <= 2'd0; emuQ <= 1'b0; doneQ <= 1'b0;
      loadQ <= '0; cmpQ <= '0;
    end else begin
      doneQ <= !softRst;
      if (softRst) begin
        runQ <= 1'b0; arQ <= 1'b0; ceQ <= 1'b0; ptQ <= 1'b0;
        trgQ <= 2'd0; emuQ <= 1'b0;
        loadQ <= '0; cmpQ <= '0;
      end else begin
        if (oneShotDone) runQ <= 1'b0;
        if (busWe) begin
          if (selMode) begin
            runQ <= busWdata[MODE_RUN];
            arQ  <= busWdata[MODE_AR];
            ceQ  <= busWdata[MODE_CE];
            trgQ <= busWdata[MODE_TRG+1:MODE_TRG];
            ptQ  <= busWdata[MODE_PT];
          end
          if (selLoad) loadQ <= busWdata;
          if (selCmp)  cmpQ  <= busWdata;
          if (selCfg)  emuQ  <= busWdata[CFG_EMU];
        end
      end
    end
  end

  always_comb begin
    cmd            = '0;
    cmd.clear      = softRst;
    cmd.cntWr      = busWe && selCnt && !softRst;
    cmd.trgLoad    = busWe && selTrig && !softRst;
    cmd.run        = runQ;
    cmd.autoReload = arQ;
    cmd.cmpEn      = ceQ;
    cmd.trigSel    = trgQ;
    cmd.toggle     = ptQ;
  end

  always_comb begin
    busRdata = '0;
    if (selCfg)  busRdata[CFG_EMU] = emuQ;
    if (selStat) busRdata[0] = doneQ;
    if (selMode) begin
      busRdata[MODE_RUN] = runQ;
      busRdata[MODE_AR]  = arQ;
      busRdata[MODE_CE]  = ceQ;
      busRdata[MODE_TRG+1:MODE_TRG] = trgQ;
      busRdata[MODE_PT]  = ptQ;
    end
    if (selCnt)  busRdata = countVal;
    if (selLoad) busRdata = loadQ;
    if (selCmp)  busRdata = cmpQ;
  end

  // R9: status reads not-done in the cycle after a soft reset
  a_r9_status_low: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !doneQ);
  // R4: a one-shot overflow stops counting unless software rewrites the mode
  a_r4_run_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotDone && !(busWe && selMode)) |=> !runQ);
  // R10: configuration write without the reset bit keeps load intact
  a_r10_cfg_no_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && selCfg && !busWdata[CFG_SRST]) |=> $stable(loadQ));
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
  import pwm_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  core_cmd_t     cmd,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] loadVal,
  input  logic [DW-1:0] cmpVal,
  output logic [DW-1:0] countQ,
  output logic          pwmQ,
  output logic          oneShotDone
);
  localparam logic [DW-1:0] TOP = '1;

  logic tickRun, atTop, ovfEvt, cmpEvt, evtSel;

  assign tickRun     = tickEn && cmd.run;
  assign atTop       = countQ == TOP;
  assign ovfEvt      = tickRun && atTop;
  assign cmpEvt      = tickRun && cmd.cmpEn && (countQ == cmpVal);
  assign oneShotDone = ovfEvt && !cmd.autoReload;

  always_comb begin
    unique case (cmd.trigSel)
      2'd0:    evtSel = 1'b0;
      2'd1:    evtSel = ovfEvt;
      default: evtSel = ovfEvt || cmpEvt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      pwmQ   <= 1'b0;
    end else begin
      if (cmd.clear)        countQ <= '0;
      else if (cmd.cntWr)   countQ <= wrData;
      else if (cmd.trgLoad) countQ <= loadVal;
      else if (tickRun) begin
        if (!atTop)              countQ <= countQ + 1'b1;
        else if (cmd.autoReload) countQ <= loadVal;
      end

      if (cmd.clear)       pwmQ <= 1'b0;
      else if (cmd.toggle) pwmQ <= pwmQ ^ evtSel;
      else                 pwmQ <= evtSel;
    end
  end

  // R2: without a running tick or bus write the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickRun && !cmd.clear && !cmd.cntWr && !cmd.trgLoad) |=> $stable(countQ));
  // R3: auto-reload overflow restores the load value
  a_r3_reload: assert property (@(posedge clk) disable iff (!rstN)
    (tickRun && atTop && cmd.autoReload && !cmd.clear && !cmd.cntWr && !cmd.trgLoad)
    |=> countQ == $past(loadVal));
  // R4: one-shot overflow leaves the count at all-ones
  a_r4_stop_at_top: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotDone && !cmd.clear && !cmd.cntWr && !cmd.trgLoad) |=> countQ == TOP);
  // R6: pulse mode with no trigger source never raises the pin
  a_r6_no_source: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.toggle && cmd.trigSel == 2'd0) |=> !pwmQ);
  // R7: toggle mode keeps its level between events
  a_r7_toggle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.toggle && !evtSel && !cmd.clear) |=> $stable(pwmQ));
  // R9: soft reset zeroes count and pin
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (countQ == '0 && !pwmQ));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  output logic              pwmOut
);
  core_cmd_t     cmd;
  logic [DW-1:0] countVal, loadVal, cmpVal;
  logic          oneShotDone;

  pwm_timer_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .countVal(countVal), .oneShotDone(oneShotDone),
    .busRdata(busRdata), .cmd(cmd), .loadQ(loadVal), .cmpQ(cmpVal)
  );

  pwm_timer_core #(.DW(DW)) u_core (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd), .wrData(busWdata),
    .loadVal(loadVal), .cmpVal(cmpVal), .countQ(countVal), .pwmQ(pwmOut),
    .oneShotDone(oneShotDone)
  );
endmodule

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        pwmOut;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  pwm_timer u_dut (.clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
                   .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
                   .pwmOut(pwmOut));

  typedef struct packed {
    logic [15:0] tag;
    logic [31:0] load;
    logic [31:0] cmp;
    logic [31:0] preset;
    logic [31:0] mode;
    logic [31:0] ticks;
    logic [31:0] expCnt;
    logic [31:0] expEvt;
  } vec_t;

  // mode bits: run=0x1 autoReload=0x2 cmpEn=0x40 trig ovf=0x400 both=0x800 toggle=0x1000
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{"R2", 32'hFFFFFFF0, 32'h0,        32'hFFFFFFF0, 32'h0003, 20, 32'hFFFFFFF4, 0},
    '{"R3", 32'hFFFFFFF0, 32'h0,        32'hFFFFFFF0, 32'h0403, 20, 32'hFFFFFFF4, 1},
    '{"R7", 32'hFFFFFFF0, 32'hFFFFFFF8, 32'hFFFFFFF0, 32'h1843, 40, 32'hFFFFFFF8, 4},
    '{"R5", 32'hFFFFFFF0, 32'hFFFFFFF8, 32'hFFFFFFF0, 32'h1803, 40, 32'hFFFFFFF8, 2},
    '{"R6", 32'hFFFFFFF0, 32'hFFFFFFF8, 32'hFFFFFFF0, 32'h0C43, 40, 32'hFFFFFFF8, 4},
    '{"R4", 32'hFFFFFFF0, 32'h0,        32'hFFFFFFF0, 32'h0401, 30, 32'hFFFFFFFF, 1},
    '{"R2", 32'hFFFFFFF0, 32'h0,        32'hFFFFFFF0, 32'h0402, 10, 32'hFFFFFFF0, 0},
    '{"R6", 32'hFFFFFFF0, 32'hFFFFFFF8, 32'hFFFFFFF0, 32'h0443, 40, 32'hFFFFFFF8, 2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic runTicks(input int n, input logic toggleMode, output int evts);
    logic prev;
    evts = 0;
    @(negedge clk);
    prev = pwmOut;
    tickEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (toggleMode ? (pwmOut != prev) : (pwmOut && !prev)) evts++;
      prev = pwmOut;
    end
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int ev;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    busAddr = 8'h14;
    #1 check("R9 status during reset exit", busRdata, 32'h0);
    @(negedge clk);
    #1 check("R9 status after reset", busRdata, 32'h1);
    rd(8'h24, r); check("R1 mode reset", r, 32'h0);
    rd(8'h28, r); check("R1 count reset", r, 32'h0);
    check("R9 pin reset", {31'b0, pwmOut}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      wr(8'h10, 32'h2);
      wr(8'h2C, VECS[v].load);
      wr(8'h38, VECS[v].cmp);
      wr(8'h28, VECS[v].preset);
      wr(8'h24, VECS[v].mode);
      runTicks(int'(VECS[v].ticks), VECS[v].mode[12], ev);
      rd(8'h28, r);
      check($sformatf("%s vector %0d count", VECS[v].tag, v), r, VECS[v].expCnt);
      check($sformatf("%s vector %0d events", VECS[v].tag, v), 32'(ev), VECS[v].expEvt);
    end

    // R9: soft reset through interface-control register
    wr(8'h2C, 32'h55);
    wr(8'h40, 32'h2);
    busAddr = 8'h14;
    #1 check("R9 status low after soft reset", busRdata, 32'h0);
    @(negedge clk);
    #1 check("R9 status high next cycle", busRdata, 32'h1);
    rd(8'h2C, r); check("R9 load cleared", r, 32'h0);

    // R8: preset and reload trigger
    wr(8'h28, 32'h1234);
    rd(8'h28, r); check("R8 counter preset", r, 32'h1234);
    wr(8'h2C, 32'hABCD0000);
    wr(8'h30, 32'h0);
    rd(8'h28, r); check("R8 reload trigger", r, 32'hABCD0000);

    // R1: mode register masking; R2: no ticks means no count change
    wr(8'h24, 32'hFFFFFFFF);
    rd(8'h24, r); check("R1 mode mask", r, 32'h00001C43);
    rd(8'h28, r); check("R2 no tick hold", r, 32'hABCD0000);
    rd(8'h30, r); check("R1 trigger reads zero", r, 32'h0);
    wr(8'h24, 32'h0);

    // R10: emulation flag storage without reset
    wr(8'h10, 32'h20);
    rd(8'h10, r); check("R10 flag readback", r, 32'h20);
    rd(8'h2C, r); check("R10 load kept", r, 32'hABCD0000);
    wr(8'h10, 32'h22);
    rd(8'h10, r); check("R9 cfg soft reset clears flag", r, 32'h0);

    // R4: one-shot clears run
    wr(8'h28, 32'hFFFFFFFE);
    wr(8'h24, 32'h0401);
    runTicks(3, 1'b0, ev);
    rd(8'h24, r); check("R4 run cleared", r, 32'h0400);
    rd(8'h28, r); check("R4 count held", r, 32'hFFFFFFFF);

    // R7: toggle pin stays high, soft reset drives it low
    wr(8'h28, 32'hFFFFFFFF);
    wr(8'h24, 32'h1403);
    runTicks(1, 1'b1, ev);
    repeat (2) @(negedge clk);
    check("R7 toggle level held", {31'b0, pwmOut}, 32'h1);
    wr(8'h40, 32'h2);
    check("R9 pin low after soft reset", {31'b0, pwmOut}, 32'h0);

    // R8: bus preset beats a running tick
    wr(8'h24, 32'h0003);
    @(negedge clk);
    tickEn = 1'b1;
    busAddr = 8'h28; busWdata = 32'h77; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0;
    rd(8'h28, r); check("R8 write priority", r, 32'h77);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule